// File: doc/BRIEF.md
# Transmit Flow-Control Credit Tracker

This block keeps count of the transmit flow-control credits used in each of the six PCI Express credit classes. The classes are posted, non-posted and completion traffic, and each has a header pool and a data pool. The link layer supplies three things: the credit limit of every pool, a flag per pool that marks unlimited credit, and a one-cycle consume pulse per pool. The block keeps a consumed counter for each pool. For each traffic type it reports whether a candidate packet of a given payload length fits in the credit that remains.

One header credit stands for 20 bytes of header, and one data credit stands for four dwords of payload. The remaining room in a pool is the limit minus the consumed count, taken modulo the counter width, so both counters may wrap freely. A pool flagged as unlimited always has room. A consume pattern that breaks the one-header-with-at-most-one-data rule raises an error flag in the next cycle.

Top module: `txfc_credit_tracker`

## Requirements
- R1: The consume and unlimited vectors share one bit order. Bit 5 is posted header, bit 4 posted data, bit 3 non-posted header, bit 2 non-posted data, bit 1 completion header and bit 0 completion data. Fit bit 2 is posted, bit 1 non-posted and bit 0 completion.
- R2: Each consume bit that is high at a clock edge adds exactly one to that pool's consumed counter. The new count governs the fit outputs from the cycle after that edge.
- R3: A pool's room is (registered limit − consumed) modulo 2^W, with W = 8 for header pools and W = 12 for data pools. Counters wrap without saturating.
- R4: The legal consume patterns in one cycle are: nothing, a single header bit, or a single header bit together with a single data bit. Any other pattern drives proto_err high in the following cycle, and a legal pattern drives it low. All bits are counted either way.
- R5: While a pool's unlimited bit is high, that pool always counts as having room, whatever its counters hold. The flag acts in the same cycle it is presented.
- R6: A synchronous active-high reset clears every consumed counter and the limit registers. All fit outputs stay low until limits_valid has been sampled high at a clock edge.
- R7: A traffic type fits only if its header room is at least 1 and its data room is at least ceil(req_payload_dw / 4). A zero payload needs no data credit.
- R8: Limits are registered at every clock edge. A changed limit affects the fit outputs from the cycle after it is presented.
- R9: The fit outputs follow req_payload_dw within the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| limits_valid | input | 1 | Limit inputs carry valid values |
| lim_hdr_post | input | 8 | Posted header credit limit |
| lim_dat_post | input | 12 | Posted data credit limit |
| lim_hdr_np | input | 8 | Non-posted header credit limit |
| lim_dat_np | input | 12 | Non-posted data credit limit |
| lim_hdr_cpl | input | 8 | Completion header credit limit |
| lim_dat_cpl | input | 12 | Completion data credit limit |
| infinite_vec | input | 6 | Per-pool unlimited-credit flags (R1 order) |
| consume_vec | input | 6 | Per-pool consume pulses (R1 order) |
| req_payload_dw | input | 11 | Payload length of the candidate packet in dwords |
| fit | output | 3 | Candidate fits: [2] posted, [1] non-posted, [0] completion |
| proto_err | output | 1 | Illegal consume pattern seen in the previous cycle |

## Verification
The fit outputs are combinational in the payload length and the unlimited flags, so they are checked in the same cycle those inputs change. Consume pulses and limit changes pass through one register, so their effect on fit is checked only one edge later. proto_err also lags its consume pattern by one edge. The bench drives inputs on the falling edge and checks fit shortly after. It updates its own counters, limit copy and expected error at each rising edge, so every comparison lines up with these latencies.

// File: rtl/txfc_pkg.sv
package txfc_pkg;
  localparam int NUM_TYPES = 3;
  localparam int NUM_POOLS = 2 * NUM_TYPES;

  // pool index: header of type t sits at 2t+1, data at 2t
  typedef enum logic [2:0] {
    POOL_CPL_DAT  = 3'd0,
    POOL_CPL_HDR  = 3'd1,
    POOL_NP_DAT   = 3'd2,
    POOL_NP_HDR   = 3'd3,
    POOL_POST_DAT = 3'd4,
    POOL_POST_HDR = 3'd5
  } pool_e;

  function automatic logic consume_ok(input logic [NUM_POOLS-1:0] c);
    logic [1:0] n_hdr;
    logic [1:0] n_dat;
    n_hdr = 2'(c[POOL_POST_HDR]) + 2'(c[POOL_NP_HDR]) + 2'(c[POOL_CPL_HDR]);
    n_dat = 2'(c[POOL_POST_DAT]) + 2'(c[POOL_NP_DAT]) + 2'(c[POOL_CPL_DAT]);
    return (n_hdr <= 2'd1) && (n_dat <= n_hdr);
  endfunction
endpackage

// File: rtl/txfc_pool_ctr.sv
module txfc_pool_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         consume_i,
  input  logic         infinite_i,
  input  logic         valid_i,
  input  logic [W-1:0] limit_i,
  input  logic [W-1:0] need_i,
  output logic         has_room_o
);
  logic [W-1:0] limit_q;
  logic [W-1:0] used_q;
  logic [W-1:0] room;
  logic         armed_q;

  function automatic logic [W-1:0] room_of(input logic [W-1:0] lim,
                                           input logic [W-1:0] used);
    return lim - used;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= '0;
      used_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      limit_q <= limit_i;
      used_q  <= used_q + W'(consume_i);
      armed_q <= 1'b1;
    end
  end

  assign room       = room_of(limit_q, used_q);
  assign has_room_o = valid_i && (infinite_i || (room >= need_i));

  // R2: one pulse, one credit
  a_r2_count_step: assert property (@(posedge clk) disable iff (rst || !armed_q)
    used_q == $past(used_q) + W'($past(consume_i)));

  // R6: reset clears the counter
  a_r6_reset_clear: assert property (@(posedge clk)
    rst |=> (used_q == '0 && limit_q == '0));
endmodule

// File: rtl/txfc_consume_check.sv
module txfc_consume_check
  import txfc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_POOLS-1:0] consume_i,
  output logic                 err_o
);
  logic bad_now;
  assign bad_now = !consume_ok(consume_i);

  always_ff @(posedge clk) begin
    if (rst) err_o <= 1'b0;
    else     err_o <= bad_now;
  end

  // R4: two header pulses at once are always flagged
  a_r4_two_hdr_flag: assert property (@(posedge clk) disable iff (rst)
    ($countones({consume_i[POOL_POST_HDR], consume_i[POOL_NP_HDR], consume_i[POOL_CPL_HDR]}) > 1)
      |=> err_o);

  // R4: a quiet cycle never raises the flag
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (consume_i == '0) |=> !err_o);
endmodule

// File: rtl/txfc_credit_tracker.sv
module txfc_credit_tracker
  import txfc_pkg::*;
#(
  parameter int HDR_W = 8,
  parameter int DAT_W = 12,
  parameter int PLD_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             limits_valid,
  input  logic [HDR_W-1:0] lim_hdr_post,
  input  logic [DAT_W-1:0] lim_dat_post,
  input  logic [HDR_W-1:0] lim_hdr_np,
  input  logic [DAT_W-1:0] lim_dat_np,
  input  logic [HDR_W-1:0] lim_hdr_cpl,
  input  logic [DAT_W-1:0] lim_dat_cpl,
  input  logic [5:0]       infinite_vec,
  input  logic [5:0]       consume_vec,
  input  logic [PLD_W-1:0] req_payload_dw,
  output logic [2:0]       fit,
  output logic             proto_err
);
  localparam int NEED_W = PLD_W - 1;

  logic [HDR_W-1:0] hdr_lim [NUM_TYPES];
  logic [DAT_W-1:0] dat_lim [NUM_TYPES];
  logic [NUM_TYPES-1:0] hdr_room;
  logic [NUM_TYPES-1:0] dat_room;
  logic             valid_q;
  logic [PLD_W:0]   dw_round;
  logic [DAT_W-1:0] dat_need;

  assign hdr_lim[0] = lim_hdr_cpl;
  assign hdr_lim[1] = lim_hdr_np;
  assign hdr_lim[2] = lim_hdr_post;
  assign dat_lim[0] = lim_dat_cpl;
  assign dat_lim[1] = lim_dat_np;
  assign dat_lim[2] = lim_dat_post;

  // ceil(dw/4): four dwords per data credit
  assign dw_round = {1'b0, req_payload_dw} + (PLD_W+1)'(3);
  assign dat_need = DAT_W'(dw_round[PLD_W:2]);

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= limits_valid;
  end

  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
    txfc_pool_ctr #(.W(HDR_W)) u_hdr (
      .clk        (clk),
      .rst        (rst),
      .consume_i  (consume_vec[2*t+1]),
      .infinite_i (infinite_vec[2*t+1]),
      .valid_i    (valid_q),
      .limit_i    (hdr_lim[t]),
      .need_i     (HDR_W'(1)),
      .has_room_o (hdr_room[t])
    );
    txfc_pool_ctr #(.W(DAT_W)) u_dat (
      .clk        (clk),
      .rst        (rst),
      .consume_i  (consume_vec[2*t]),
      .infinite_i (infinite_vec[2*t]),
      .valid_i    (valid_q),
      .limit_i    (dat_lim[t]),
      .need_i     (dat_need),
      .has_room_o (dat_room[t])
    );
    assign fit[t] = hdr_room[t] && dat_room[t];

    // R5: an unlimited pair always fits once limits are valid
    a_r5_inf_fits: assert property (@(posedge clk) disable iff (rst)
      (valid_q && infinite_vec[2*t+1] && infinite_vec[2*t]) |-> fit[t]);
  end

  txfc_consume_check u_chk (
    .clk       (clk),
    .rst       (rst),
    .consume_i (consume_vec),
    .err_o     (proto_err)
  );

  // R6: nothing fits before valid limits were sampled
  a_r6_no_fit_early: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> (fit == 3'b000));

  if (NEED_W > DAT_W) begin : g_bad_width
    initial $error("payload width too large for data counter");
  end
endmodule

// File: tb/txfc_credit_tracker_test.sv
`timescale 1ns/1ps
module txfc_credit_tracker_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst;
  logic        limits_valid;
  logic [7:0]  hl [3];
  logic [11:0] dl [3];
  logic [5:0]  inf_v;
  logic [5:0]  cons_v;
  logic [10:0] pdw;
  logic [2:0]  fit;
  logic        proto_err;

  txfc_credit_tracker uut (
    .clk(clk), .rst(rst), .limits_valid(limits_valid),
    .lim_hdr_post(hl[2]), .lim_dat_post(dl[2]),
    .lim_hdr_np(hl[1]),   .lim_dat_np(dl[1]),
    .lim_hdr_cpl(hl[0]),  .lim_dat_cpl(dl[0]),
    .infinite_vec(inf_v), .consume_vec(cons_v),
    .req_payload_dw(pdw), .fit(fit), .proto_err(proto_err)
  );

  int total = 0;
  int fails = 0;

  // bench model state (updated at each rising edge)
  logic [7:0]  m_hlim [3];
  logic [11:0] m_dlim [3];
  logic [7:0]  m_hused [3];
  logic [11:0] m_dused [3];
  logic        m_valid;
  logic        m_err;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic bad_pattern(input logic [5:0] c);
    int nh, nd;
    nh = int'(c[5]) + int'(c[3]) + int'(c[1]);
    nd = int'(c[4]) + int'(c[2]) + int'(c[0]);
    return (nh > 1) || (nd > 1) || (nd == 1 && nh == 0);
  endfunction

  function automatic logic [2:0] exp_fit(input logic [5:0] inf, input logic [10:0] dw);
    logic [2:0] r;
    int need;
    need = (int'(dw) + 3) / 4;
    for (int t = 0; t < 3; t++) begin
      logic [7:0]  hr;
      logic [11:0] dr;
      hr = m_hlim[t] - m_hused[t];
      dr = m_dlim[t] - m_dused[t];
      r[t] = m_valid && (inf[2*t+1] || hr >= 8'd1) && (inf[2*t] || int'(dr) >= need);
    end
    return r;
  endfunction

  task automatic model_edge();
    for (int t = 0; t < 3; t++) begin
      m_hused[t] = m_hused[t] + 8'(cons_v[2*t+1]);
      m_dused[t] = m_dused[t] + 12'(cons_v[2*t]);
      m_hlim[t]  = hl[t];
      m_dlim[t]  = dl[t];
    end
    m_valid = limits_valid;
    m_err   = bad_pattern(cons_v);
  endtask

  task automatic legal_consume(output logic [5:0] c);
    int k;
    c = '0;
    k = $urandom % 8;
    if (k >= 2) begin
      int h;
      h = $urandom % 3;
      c[2*h+1] = 1'b1;                       // R1 header bit positions
      if (k >= 5) c[2*($urandom % 3)] = 1'b1; // optional single data bit
    end
  endtask

  initial begin
    #(5.0 * 200000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst = 1'b1; limits_valid = 1'b0; inf_v = '0; cons_v = '0; pdw = '0;
    for (int t = 0; t < 3; t++) begin hl[t] = 8'd5; dl[t] = 12'd40; end
    for (int t = 0; t < 3; t++) begin
      m_hlim[t] = '0; m_dlim[t] = '0; m_hused[t] = '0; m_dused[t] = '0;
    end
    m_valid = 1'b0; m_err = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 reset fit", fit, 3'b000);
    check("R6 reset err", proto_err, 1'b0);
    rst = 1'b0;
    @(posedge clk);   // limits_valid still low here
    @(negedge clk);
    inf_v = 6'h3F;
    #1 check("R6 no fit before valid", fit, 3'b000);
    inf_v = '0;

    // directed: R8 limit lag, R7 boundary, R9 same-cycle payload, R5, R1
    limits_valid = 1'b1;
    for (int t = 0; t < 3; t++) begin hl[t] = 8'd0; dl[t] = 12'd8; end
    @(posedge clk); model_edge();
    @(negedge clk);
    hl[2] = 8'd1;
    #1 check("R8 raised limit not yet seen", fit, 3'b000);
    @(posedge clk); model_edge();
    @(negedge clk);
    pdw = 11'd32;
    #1 check("R7 exact data room fits", fit, 3'b100);
    pdw = 11'd33;
    #1 check("R9 payload one dword over", fit, 3'b000);
    inf_v = 6'b010000;
    #1 check("R5 R1 posted data unlimited", fit, 3'b100);
    inf_v = 6'b000011;
    #1 check("R5 R1 completion pair unlimited", fit, 3'b001);
    inf_v = '0; pdw = 11'd0;
    // R2: consume the only posted header credit
    cons_v = 6'b100000;
    @(posedge clk); model_edge();
    @(negedge clk);
    cons_v = '0;
    #1 check("R2 posted header exhausted", fit, 3'b000);
    check("R4 legal single header", proto_err, 1'b0);
    // R4: two headers at once
    cons_v = 6'b101000;
    @(posedge clk); model_edge();
    @(negedge clk);
    cons_v = '0;
    check("R4 two headers flagged", proto_err, 1'b1);
    // R4: data without header
    cons_v = 6'b000100;
    @(posedge clk); model_edge();
    @(negedge clk);
    cons_v = '0;
    check("R4 lone data flagged", proto_err, 1'b1);
    @(posedge clk); model_edge();

    // sweep: random legal traffic near the room boundary, with wrap (R3)
    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      check("R4 err flag", proto_err, m_err);
      if (cyc % 7 == 0) begin
        for (int t = 0; t < 3; t++) begin
          hl[t] = m_hused[t] + 8'($urandom % 3);
          dl[t] = m_dused[t] + 12'($urandom % 24);
        end
      end
      inf_v = '0;
      for (int b = 0; b < 6; b++) if ($urandom % 8 == 0) inf_v[b] = 1'b1;
      if (cyc % 97 == 50) cons_v = 6'b100010;
      else legal_consume(cons_v);
      pdw = 11'($urandom % 90);
      #1 check("R3 R7 fit vs model", fit, exp_fit(inf_v, pdw));
      pdw = 11'($urandom % 90);
      #1 check("R9 fit same cycle", fit, exp_fit(inf_v, pdw));
      @(posedge clk); model_edge();
    end
    @(negedge clk);
    check("R4 final err", proto_err, m_err);

    // R6: reset mid-run clears counters
    rst = 1'b1; cons_v = '0; inf_v = '0;
    @(posedge clk);
    for (int t = 0; t < 3; t++) begin m_hused[t] = '0; m_dused[t] = '0; end
    m_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    for (int t = 0; t < 3; t++) begin hl[t] = 8'd1; dl[t] = 12'd1; end
    pdw = 11'd4;
    #1 check("R6 fit low after reset", fit, 3'b000);
    @(posedge clk); model_edge();
    @(negedge clk);
    #1 check("R6 counters cleared", fit, 3'b111);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule